// File: doc/BRIEF.md
# Clock Tree Configuration Block

This block holds the registers that set up a chip's clock tree from one system reference clock. Software reaches it through a simple device-control register port: a select strobe, a write flag, a small register index and 32-bit data in both directions. Three registers can be written. The divider register carries six 2-bit stage dividers. The PLL register carries the enable and bypass controls, the feedback multiplier and the forward divide. The UART register carries two 7-bit baud-clock dividers. Two more registers can only be read: a strap status word whose bit 0 reports PLL lock, and a fixed identity word.

The block decodes each field into the factor it stands for. Some fields add one, one adds two, one is subtracted from eight, and some treat zero as the largest value. It reports whether the PLL is in use. From the reference frequency parameter it computes the VCO frequency and raises a fault flag when that frequency falls outside the allowed window. It also outputs the divide ratio of every stage.

Eight clock domains each receive a clock-enable pulse. Each pulse lasts one clock cycle and repeats at that domain's total ratio from the PLL output, counted in cycles of `clk`. `clk` stands for the PLL output. Writing any of the three writable registers restarts all the divider counters.

Top module: `clktree_cfg`

## Requirements
- R1: After reset the registers read as follows. Index 0 (divider register) reads 0x00021002. Index 1 (PLL register) reads 0x80A552BE. Index 2 (UART register) reads 0x00004646. Index 3 (strap word) reads 0x00000011, because the PLL is in use at reset.
- R2: A write stores the data ANDed with a mask: 0x00633333 for the divider register, 0xC0F73FFF for the PLL register and 0x003F7F7F for the UART register. A read of the register returns exactly that stored value.
- R3: Writes to index 3 (strap word) and index 4 (identity word) are ignored. Index 4 always reads the ID_VALUE parameter. Any unmapped index reads as zero.
- R4: `pll_active` is 1 only when PLL register bit 31 is 1 and bit 30 is 0.
- R5: `fb_mult` equals PLL register bits 23:20, except that a field value of 0 gives 16.
- R6: `fwd_div` equals 8 minus PLL register bits 18:16.
- R7: While the PLL is in use, `vco_fault` is 1 exactly when SYSCLK_HZ × fb_mult × fwd_div is below VCO_MIN_HZ or above VCO_MAX_HZ. While the PLL is bypassed, `vco_fault` is 0.
- R8: Bit 0 of the strap word is set one cycle after the PLL register selects PLL use. It is cleared one cycle after PLL register bit 30 is 1. When bits 31 and 30 are both 0, the bit keeps its value.
- R9: The stage ratios are taken from the divider register. Entry 0 (CPU) is bits 21:20 + 1. Entry 1 (bus) is bits 17:16 + 1. Entry 2 (peripheral bus) is bits 13:12 + 1. Entry 3 (external bus) is bits 9:8 + 2. Entry 4 (channel engine) is bits 5:4 + 1. Entry 5 (PCI) is bits 1:0 + 1.
- R10: Stage ratio entry 6 is UART register bits 6:0 and entry 7 is bits 14:8. In both cases a field value of 0 gives 128.
- R11: Each domain raises its `tick_en` bit once every N cycles. For CPU, N is the CPU ratio. For the bus, N is CPU × bus. For entries 2 to 5, N is CPU × bus × that entry's ratio. For the two UARTs, N is the UART ratio.
- R12: A write to index 0, 1 or 2 restarts every divider. After such a write, the first enable of a domain with total ratio N is high in the Nth cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; also stands for the PLL output tick |
| rst_n | input | 1 | Active-low asynchronous reset |
| dcr_en | input | 1 | Register access strobe |
| dcr_wr | input | 1 | 1 = write, 0 = read |
| dcr_addr | input | ADDR_W | Register index |
| dcr_wdata | input | 32 | Write data |
| dcr_rdata | output | 32 | Read data; 0 when no read is in progress |
| pll_active | output | 1 | PLL in use (not bypassed) |
| vco_fault | output | 1 | VCO frequency outside the allowed window |
| fb_mult | output | 5 | Decoded feedback multiplier, 1 to 16 |
| fwd_div | output | 4 | Decoded forward divide, 1 to 8 |
| stage_div | output | 8×CNT_W | Per-domain stage ratio, entry order CPU, bus, peripheral, external, channel, PCI, UART0, UART1 |
| tick_en | output | 8 | Per-domain clock-enable pulse, same entry order |

## Verification
The bench builds the block with SYSCLK_HZ = 40 MHz and keeps the default VCO window of 500 MHz to 1 GHz. With these values, multiplier-times-divide products from 13 to 25 pass and all others fault, so the sweep over all 128 multiplier and forward-divide pairs reaches both edges of the window. The bench writes all 4096 combinations of the six 2-bit stage fields, which shows how the write mask interacts with each field decode. It writes all 128 values of each UART field, including the zero-means-128 case. The enable pulses are counted over a fixed window for several ratio sets. The restart behaviour is checked cycle by cycle after writes to the UART register and to the PLL register.

// File: rtl/clktree_pkg.sv
package clktree_pkg;
   localparam int NDOM    = 8;
   localparam int D_CPU   = 0;
   localparam int D_BUS   = 1;
   localparam int D_PERI  = 2;
   localparam int D_EXT   = 3;
   localparam int D_CHAN  = 4;
   localparam int D_PCI   = 5;
   localparam int D_UART0 = 6;
   localparam int D_UART1 = 7;

   localparam int unsigned RA_DIV   = 0;
   localparam int unsigned RA_PLL   = 1;
   localparam int unsigned RA_UART  = 2;
   localparam int unsigned RA_STRAP = 3;
   localparam int unsigned RA_ID    = 4;

   localparam logic [31:0] DIV_WMASK  = 32'h0063_3333;
   localparam logic [31:0] PLL_WMASK  = 32'hC0F7_3FFF;
   localparam logic [31:0] UART_WMASK = 32'h003F_7F7F;
   localparam logic [31:0] DIV_RST    = 32'h0002_1002;
   localparam logic [31:0] PLL_RST    = 32'h80A5_52BE;
   localparam logic [31:0] UART_RST   = 32'h0000_4646;

   function automatic logic pll_in_use(input logic [31:0] r);
      return r[31] & ~r[30];
   endfunction

   function automatic logic [4:0] mult_of(input logic [3:0] f);
      return (f == 4'd0) ? 5'd16 : {1'b0, f};
   endfunction

   function automatic logic [3:0] fwd_of(input logic [2:0] f);
      return 4'd8 - {1'b0, f};
   endfunction

   function automatic logic [7:0] uart_of(input logic [6:0] f);
      return (f == 7'd0) ? 8'd128 : {1'b0, f};
   endfunction
endpackage

// File: rtl/clktree_regs.sv
module clktree_regs
   import clktree_pkg::*;
#(
   parameter int          ADDR_W     = 3,
   parameter logic [31:0] ID_VALUE   = 32'h4C0C_0A51,
   parameter logic [31:0] STRAP_INIT = 32'h0000_0010
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [31:0]       div_q,
   output logic [31:0]       pll_q,
   output logic [31:0]       uart_q,
   output logic              cfg_write
);
   localparam logic LOCK_RST = pll_in_use(PLL_RST) ? 1'b1 : STRAP_INIT[0];

   if (ADDR_W < 3) begin : g_chk_addr
      $error("clktree_regs: ADDR_W must cover five registers");
   end

   logic wr_hit, hit_div, hit_pll, hit_uart, lock_q;

   assign wr_hit    = bus_en & bus_wr;
   assign hit_div   = wr_hit && (bus_addr == ADDR_W'(RA_DIV));
   assign hit_pll   = wr_hit && (bus_addr == ADDR_W'(RA_PLL));
   assign hit_uart  = wr_hit && (bus_addr == ADDR_W'(RA_UART));
   assign cfg_write = hit_div | hit_pll | hit_uart;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q  <= DIV_RST;
         pll_q  <= PLL_RST;
         uart_q <= UART_RST;
      end else begin
         if (hit_div)  div_q  <= bus_wdata & DIV_WMASK;
         if (hit_pll)  pll_q  <= bus_wdata & PLL_WMASK;
         if (hit_uart) uart_q <= bus_wdata & UART_WMASK;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  lock_q <= LOCK_RST;
      else if (pll_in_use(pll_q))  lock_q <= 1'b1;
      else if (pll_q[30])          lock_q <= 1'b0;
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_en && !bus_wr) begin
         case (bus_addr)
            ADDR_W'(RA_DIV):   bus_rdata = div_q;
            ADDR_W'(RA_PLL):   bus_rdata = pll_q;
            ADDR_W'(RA_UART):  bus_rdata = uart_q;
            ADDR_W'(RA_STRAP): bus_rdata = {STRAP_INIT[31:1], lock_q};
            ADDR_W'(RA_ID):    bus_rdata = ID_VALUE;
            default:           bus_rdata = '0;
         endcase
      end
   end

   // R2: stored value is the masked write data
   p_div_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
      hit_div |=> div_q == ($past(bus_wdata) & DIV_WMASK));

   // R3: writes to read-only words leave the writable registers alone
   p_ro_noeffect_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && (bus_addr == ADDR_W'(RA_STRAP) || bus_addr == ADDR_W'(RA_ID)))
      |=> ($stable(div_q) && $stable(pll_q) && $stable(uart_q)));

   // R8: lock follows the PLL register one cycle later
   p_lock_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pll_in_use(pll_q) |=> lock_q);

   p_lock_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pll_q[30] |=> !lock_q);
endmodule

// File: rtl/clktree_decode.sv
module clktree_decode
   import clktree_pkg::*;
#(
   parameter longint unsigned SYSCLK_HZ  = 64'd33_333_333,
   parameter longint unsigned VCO_MIN_HZ = 64'd500_000_000,
   parameter longint unsigned VCO_MAX_HZ = 64'd1_000_000_000,
   parameter int              CNT_W      = 8
) (
   input  logic [31:0]                 div_q,
   input  logic [31:0]                 pll_q,
   input  logic [31:0]                 uart_q,
   output logic                        pll_used,
   output logic                        vco_fault,
   output logic [4:0]                  fb_mult,
   output logic [3:0]                  fwd_div,
   output logic [NDOM-1:0][CNT_W-1:0]  stage_div,
   output logic [NDOM-1:0][CNT_W-1:0]  cum_div
);
   if (CNT_W < 8) begin : g_chk_cnt
      $error("clktree_decode: CNT_W must hold a ratio of 128");
   end
   if (VCO_MIN_HZ >= VCO_MAX_HZ) begin : g_chk_vco
      $error("clktree_decode: VCO window is empty");
   end

   logic [63:0]      vco_hz;
   logic [CNT_W-1:0] bus_tot;
   logic             unused_bits;

   assign unused_bits = ^{div_q[31:22], div_q[19:18], div_q[15:14], div_q[11:10],
                          div_q[7:6], div_q[3:2], pll_q[29:24], pll_q[19],
                          pll_q[15:0], uart_q[31:15], uart_q[7]};

   assign pll_used  = pll_in_use(pll_q);
   assign fb_mult   = mult_of(pll_q[23:20]);
   assign fwd_div   = fwd_of(pll_q[18:16]);
   assign vco_hz    = 64'(SYSCLK_HZ) * 64'(fb_mult) * 64'(fwd_div);
   assign vco_fault = pll_used && ((vco_hz < 64'(VCO_MIN_HZ)) || (vco_hz > 64'(VCO_MAX_HZ)));

   assign stage_div[D_CPU]   = CNT_W'(div_q[21:20]) + CNT_W'(1);
   assign stage_div[D_BUS]   = CNT_W'(div_q[17:16]) + CNT_W'(1);
   assign stage_div[D_PERI]  = CNT_W'(div_q[13:12]) + CNT_W'(1);
   assign stage_div[D_EXT]   = CNT_W'(div_q[9:8])   + CNT_W'(2);
   assign stage_div[D_CHAN]  = CNT_W'(div_q[5:4])   + CNT_W'(1);
   assign stage_div[D_PCI]   = CNT_W'(div_q[1:0])   + CNT_W'(1);
   assign stage_div[D_UART0] = CNT_W'(uart_of(uart_q[6:0]));
   assign stage_div[D_UART1] = CNT_W'(uart_of(uart_q[14:8]));

   assign bus_tot          = stage_div[D_CPU] * stage_div[D_BUS];
   assign cum_div[D_CPU]   = stage_div[D_CPU];
   assign cum_div[D_BUS]   = bus_tot;
   for (genvar g = D_PERI; g <= D_PCI; g++) begin : g_bus_child
      assign cum_div[g] = bus_tot * stage_div[g];
   end
   assign cum_div[D_UART0] = stage_div[D_UART0];
   assign cum_div[D_UART1] = stage_div[D_UART1];
endmodule

// File: rtl/clktree_tick.sv
module clktree_tick #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [CNT_W-1:0] ratio,
   output logic             tick
);
   logic [CNT_W-1:0] cnt_q;

   assign tick = (cnt_q >= ratio - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (restart) cnt_q <= '0;
      else if (tick)    cnt_q <= '0;
      else              cnt_q <= cnt_q + CNT_W'(1);
   end

   // R11: count stays inside the period
   p_cnt_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < ratio);

   // R11: no back-to-back pulses for ratios above one
   p_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !restart && ratio > CNT_W'(1)) |=> !tick);

   // R12: restart returns the counter to the start of a period
   p_restart_r12: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> cnt_q == '0);
endmodule

// File: rtl/clktree_cfg.sv
module clktree_cfg
   import clktree_pkg::*;
#(
   parameter int              ADDR_W     = 3,
   parameter int              CNT_W      = 8,
   parameter longint unsigned SYSCLK_HZ  = 64'd33_333_333,
   parameter longint unsigned VCO_MIN_HZ = 64'd500_000_000,
   parameter longint unsigned VCO_MAX_HZ = 64'd1_000_000_000,
   parameter logic [31:0]     ID_VALUE   = 32'h4C0C_0A51,
   parameter logic [31:0]     STRAP_INIT = 32'h0000_0010
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       dcr_en,
   input  logic                       dcr_wr,
   input  logic [ADDR_W-1:0]          dcr_addr,
   input  logic [31:0]                dcr_wdata,
   output logic [31:0]                dcr_rdata,
   output logic                       pll_active,
   output logic                       vco_fault,
   output logic [4:0]                 fb_mult,
   output logic [3:0]                 fwd_div,
   output logic [NDOM-1:0][CNT_W-1:0] stage_div,
   output logic [NDOM-1:0]            tick_en
);
   logic [31:0]                div_q, pll_q, uart_q;
   logic                       cfg_write;
   logic [NDOM-1:0][CNT_W-1:0] cum_div;

   clktree_regs #(
      .ADDR_W(ADDR_W), .ID_VALUE(ID_VALUE), .STRAP_INIT(STRAP_INIT)
   ) regs_i (
      .clk(clk), .rst_n(rst_n), .bus_en(dcr_en), .bus_wr(dcr_wr),
      .bus_addr(dcr_addr), .bus_wdata(dcr_wdata), .bus_rdata(dcr_rdata),
      .div_q(div_q), .pll_q(pll_q), .uart_q(uart_q), .cfg_write(cfg_write)
   );

   clktree_decode #(
      .SYSCLK_HZ(SYSCLK_HZ), .VCO_MIN_HZ(VCO_MIN_HZ),
      .VCO_MAX_HZ(VCO_MAX_HZ), .CNT_W(CNT_W)
   ) dec_i (
      .div_q(div_q), .pll_q(pll_q), .uart_q(uart_q),
      .pll_used(pll_active), .vco_fault(vco_fault),
      .fb_mult(fb_mult), .fwd_div(fwd_div),
      .stage_div(stage_div), .cum_div(cum_div)
   );

   for (genvar d = 0; d < NDOM; d++) begin : g_dom
      clktree_tick #(.CNT_W(CNT_W)) tick_i (
         .clk(clk), .rst_n(rst_n), .restart(cfg_write),
         .ratio(cum_div[d]), .tick(tick_en[d])
      );
   end

   // R7: bypass never reports a VCO fault
   p_bypass_novco_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !pll_active |-> !vco_fault);

   // R5: the multiplier is never zero
   p_mult_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fb_mult != 5'd0);
endmodule

// File: tb/clktree_cfg_tb_top.sv
module clktree_cfg_tb_top;
   localparam int CNT_W = 8;
   localparam logic [31:0] IDV = 32'h4C0C_0A51;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dcr_en = 1'b0, dcr_wr = 1'b0;
   logic [2:0] dcr_addr = '0;
   logic [31:0] dcr_wdata = '0;
   logic [31:0] dcr_rdata;
   logic pll_active, vco_fault;
   logic [4:0] fb_mult;
   logic [3:0] fwd_div;
   logic [7:0][CNT_W-1:0] stage_div;
   logic [7:0] tick_en;

   int nchk = 0, nerr = 0;
   bit done = 0;

   always #10 clk = ~clk;

   clktree_cfg #(.ADDR_W(3), .CNT_W(CNT_W), .SYSCLK_HZ(64'd40_000_000),
                 .ID_VALUE(IDV)) dut_i (
      .clk(clk), .rst_n(rst_n), .dcr_en(dcr_en), .dcr_wr(dcr_wr),
      .dcr_addr(dcr_addr), .dcr_wdata(dcr_wdata), .dcr_rdata(dcr_rdata),
      .pll_active(pll_active), .vco_fault(vco_fault), .fb_mult(fb_mult),
      .fwd_div(fwd_div), .stage_div(stage_div), .tick_en(tick_en)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("  Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      dcr_en = 1; dcr_wr = 1; dcr_addr = a; dcr_wdata = d;
      @(negedge clk);
      dcr_en = 0; dcr_wr = 0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      dcr_en = 1; dcr_wr = 0; dcr_addr = a;
      #2 d = dcr_rdata;
      dcr_en = 0;
   endtask

   function automatic int u_of(input int f);
      return (f == 0) ? 128 : f;
   endfunction

   // Writes div and uart words, then counts enables over L cycles (R11)
   task automatic count_cfg(input logic [31:0] dw, input logic [31:0] uw);
      int cnt [8];
      int n [8];
      int L = 300;
      logic [31:0] m;
      m = dw & 32'h0063_3333;
      n[0] = int'(m[21:20]) + 1;
      n[1] = n[0] * (int'(m[17:16]) + 1);
      n[2] = n[1] * (int'(m[13:12]) + 1);
      n[3] = n[1] * (int'(m[9:8]) + 2);
      n[4] = n[1] * (int'(m[5:4]) + 1);
      n[5] = n[1] * (int'(m[1:0]) + 1);
      n[6] = u_of(int'(uw[6:0]));
      n[7] = u_of(int'(uw[14:8]));
      wr(3'd0, dw);
      wr(3'd2, uw);
      for (int d = 0; d < 8; d++) cnt[d] = 0;
      for (int k = 1; k <= L; k++) begin
         for (int d = 0; d < 8; d++) if (tick_en[d]) cnt[d]++;
         @(negedge clk);
      end
      for (int d = 0; d < 8; d++) chk("R11 tick count", cnt[d], L / n[d]);
   endtask

   initial begin
      #(20 * 150000);
      nerr++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
   end

   initial begin
      logic [31:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1 reset values
      rd(3'd0, r); chk("R1 div reset", r, 32'h0002_1002);
      rd(3'd1, r); chk("R1 pll reset", r, 32'h80A5_52BE);
      rd(3'd2, r); chk("R1 uart reset", r, 32'h0000_4646);
      rd(3'd3, r); chk("R1 strap reset", r, 32'h0000_0011);

      // R2 write masks
      wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, r); chk("R2 div mask", r, 32'h0063_3333);
      wr(3'd1, 32'hFFFF_FFFF); rd(3'd1, r); chk("R2 pll mask", r, 32'hC0F7_3FFF);
      wr(3'd2, 32'hFFFF_FFFF); rd(3'd2, r); chk("R2 uart mask", r, 32'h003F_7F7F);
      wr(3'd2, 32'h0000_0000); rd(3'd2, r); chk("R2 uart zero", r, 32'h0);

      // R3 read-only and unmapped
      wr(3'd0, 32'h0002_1002);
      wr(3'd1, 32'h80A5_52BE);
      wr(3'd3, 32'hFFFF_FFFE); rd(3'd3, r); chk("R3 strap ignores write", r, 32'h11);
      wr(3'd4, 32'h0); rd(3'd4, r); chk("R3 id value", r, IDV);
      rd(3'd0, r); chk("R3 div untouched", r, 32'h0002_1002);
      rd(3'd5, r); chk("R3 unmapped", r, 32'h0);
      rd(3'd7, r); chk("R3 unmapped", r, 32'h0);

      // R4 R5 R6 R7 sweep of multiplier and forward divide
      for (int f = 0; f < 16; f++) begin
         for (int g = 0; g < 8; g++) begin
            longint m, dv, v;
            m = (f == 0) ? 16 : f;
            dv = 8 - g;
            v = 40_000_000 * m * dv;
            wr(3'd1, 32'h8000_0000 | (f << 20) | (g << 16));
            chk("R4 active", pll_active, 1);
            chk("R5 mult", fb_mult, m);
            chk("R6 fwd", fwd_div, dv);
            chk("R7 vco fault", vco_fault,
                (v < 500_000_000 || v > 1_000_000_000) ? 1 : 0);
         end
      end
      wr(3'd1, 32'hC010_0000); chk("R4 bypass 11", pll_active, 0);
      chk("R7 bypass no fault", vco_fault, 0);
      wr(3'd1, 32'h0010_0000); chk("R4 bypass 00", pll_active, 0);
      chk("R7 bypass no fault", vco_fault, 0);
      wr(3'd1, 32'h4070_0000); chk("R4 bypass 01", pll_active, 0);

      // R8 lock bit sequence
      wr(3'd1, 32'h80A5_0000); rd(3'd3, r); chk("R8 lock set", r, 32'h11);
      wr(3'd1, 32'h0000_0000); rd(3'd3, r); chk("R8 lock held", r, 32'h11);
      wr(3'd1, 32'h4000_0000); rd(3'd3, r); chk("R8 lock clear", r, 32'h10);
      wr(3'd1, 32'h0000_0000); rd(3'd3, r); chk("R8 clear held", r, 32'h10);
      wr(3'd1, 32'h80A5_0000); rd(3'd3, r); chk("R8 lock again", r, 32'h11);
      wr(3'd1, 32'hC0A5_0000); rd(3'd3, r); chk("R8 bit30 clears", r, 32'h10);

      // R9 all 4096 stage field combinations
      for (int v = 0; v < 4096; v++) begin
         logic [31:0] w, mw;
         w = ((v & 3) << 20) | (((v >> 2) & 3) << 16) | (((v >> 4) & 3) << 12) |
             (((v >> 6) & 3) << 8) | (((v >> 8) & 3) << 4) | ((v >> 10) & 3);
         mw = w & 32'h0063_3333;
         wr(3'd0, w);
         chk("R9 cpu",  stage_div[0], int'(mw[21:20]) + 1);
         chk("R9 bus",  stage_div[1], int'(mw[17:16]) + 1);
         chk("R9 peri", stage_div[2], int'(mw[13:12]) + 1);
         chk("R9 ext",  stage_div[3], int'(mw[9:8]) + 2);
         chk("R9 chan", stage_div[4], int'(mw[5:4]) + 1);
         chk("R9 pci",  stage_div[5], int'(mw[1:0]) + 1);
      end

      // R10 uart fields
      for (int v = 0; v < 128; v++) begin
         wr(3'd2, (v) | ((127 - v) << 8));
         chk("R10 uart0", stage_div[6], u_of(v));
         chk("R10 uart1", stage_div[7], u_of(127 - v));
      end

      // R11 pulse counts
      count_cfg(32'h0002_1002, 32'h0000_4646);
      count_cfg(32'h0000_0000, 32'h0000_0101);
      count_cfg(32'h0023_3333, 32'h0000_0700);
      count_cfg(32'h0021_2213, 32'h0000_0D03);

      // R12 restart after uart write
      wr(3'd2, 32'h0000_0305);
      for (int k = 1; k <= 6; k++) begin
         chk("R12 uart0 phase", tick_en[6], (k == 5) ? 1 : 0);
         chk("R12 uart1 phase", tick_en[7], (k == 3 || k == 6) ? 1 : 0);
         @(negedge clk);
      end
      // R12 restart after PLL register write
      repeat (2) @(negedge clk);
      wr(3'd1, 32'h80A5_52BE);
      for (int k = 1; k <= 5; k++) begin
         chk("R12 pll write restart", tick_en[6], (k == 5) ? 1 : 0);
         @(negedge clk);
      end

      summary();
   end
endmodule